// File: doc/BRIEF.md
# Overcurrent and Short-Circuit Hiccup Sequencer

This block decides when the power switch of a switching regulator controller may run. It follows a run request from the enable logic and brings the converter up through a digital soft-start ramp before normal operation. It watches two fault indications coming from the analog front end. One is an overcurrent threshold crossing. The other is an output undervoltage, which is treated as a short circuit.

Either fault forces a hiccup. The switch is held off for a fixed number of clocks, and then a full soft-start begins again. The short-circuit path can be switched off by a configuration bit. Its flag is also blanked for a set number of clocks after every start, so that a rising output does not trip it.

The PWM block gates its switching with `pwm_inhibit`. The soft-start reference DAC is driven from `ss_level`. Dropping the run request at any time forces the block to off and clears every timer.

Top module: `fault_hiccup_seq`

## Requirements
- R1: After reset the block sits in the off state. `state` reads 0, `pwm_inhibit` is 1, `ss_active` is 0 and `ss_level` is 0.
- R2: In the off state, a high `run_req` moves the block to soft-start on the next clock. `ss_level` starts at 0 and rises by exactly one every `SS_DIV` clocks, never decreasing.
- R3: Once `ss_level` reaches full scale (2^`SS_W`−1), the block enters run on the following clock. Soft-start therefore lasts (2^`SS_W`−1)·`SS_DIV`+1 clocks. In run, `ss_level` stays at full scale and `pwm_inhibit` is 0.
- R4: A high `oc_flag` sampled during soft-start or run moves the block to hiccup on the next clock. In the off state the flag has no effect.
- R5: Hiccup lasts exactly `HICCUP_CYCLES` clocks, even if `oc_flag` stays high throughout. During hiccup, `pwm_inhibit` is 1 and `ss_level` is 0. The block then re-enters soft-start with `ss_level` at 0.
- R6: During the first `BLANK_CYCLES` clocks after each entry to soft-start, `uv_flag` is ignored.
- R7: With `sc_en` = 1, a high `uv_flag` sampled after blanking has elapsed, in soft-start or run, moves the block to hiccup on the next clock. When `uv_flag` is held high from the start, the block spends exactly `BLANK_CYCLES`+1 clocks in soft-start/run before hiccup.
- R8: With `sc_en` = 0, `uv_flag` never causes a hiccup.
- R9: A low `run_req` moves the block from any state to off on the next clock. It also clears the hiccup, blanking and ramp timers, so a new start gets a full soft-start and a full blanking window.
- R10: The `state` encoding is off=0, soft-start=1, run=2, hiccup=3. `pwm_inhibit` is 1 exactly in off and hiccup. `ss_active` is 1 exactly in soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Run request from enable logic |
| oc_flag | input | 1 | Overcurrent threshold crossed |
| uv_flag | input | 1 | Output undervoltage (short-circuit trip) |
| sc_en | input | 1 | Short-circuit protection enable |
| pwm_inhibit | output | 1 | Holds the power switch off |
| ss_active | output | 1 | Soft-start in progress |
| ss_level | output | SS_W | Soft-start ramp value |
| state | output | 2 | Sequencer state code |

## Verification
The checks made on every cycle are listed below:
- the forced return to off when the run request is low
- that run is only ever reached at full-scale ramp
- that the ramp never decreases during soft-start
- that run never inhibits the switch
- that every hiccup entry was preceded by a fault flag
- that no hiccup outlasts its length

Only the directed scenarios can show the exact soft-start, blanking and hiccup durations. The same holds for the silence of the undervoltage flag while blanked or disabled. The same holds for the restart of all timers after a run request drop, because these are counts over whole episodes.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
   typedef enum logic [1:0] {
      SEQ_OFF    = 2'd0,
      SEQ_RAMP   = 2'd1,
      SEQ_RUN    = 2'd2,
      SEQ_HICCUP = 2'd3
   } seq_state_t;
endpackage

// File: rtl/hiccup_flag_sync.sv
module hiccup_flag_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/hiccup_event_timer.sv
module hiccup_event_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic enable,
   output logic done
);
   localparam int CW = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (enable && cnt != LIM)
         cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LIM);
endmodule

// File: rtl/hiccup_softstart_ramp.sv
module hiccup_softstart_ramp #(
   parameter int SS_W   = 4,
   parameter int SS_DIV = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            enable,
   output logic [SS_W-1:0] level,
   output logic            full
);
   localparam logic [SS_W-1:0] FULL_SCALE = '1;

   logic step;

   generate
      if (SS_DIV == 1) begin : g_nodiv
         assign step = enable;
      end else begin : g_div
         localparam int PW = $clog2(SS_DIV);
         localparam logic [PW-1:0] PMAX = PW'(SS_DIV - 1);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre <= '0;
            else if (clear)
               pre <= '0;
            else if (enable)
               pre <= (pre == PMAX) ? '0 : pre + 1'b1;
         end
         assign step = enable && (pre == PMAX);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level <= '0;
      else if (clear)
         level <= '0;
      else if (step && level != FULL_SCALE)
         level <= level + 1'b1;
   end

   assign full = (level == FULL_SCALE);
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
   import hiccup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_req,
   input  logic       fault,
   input  logic       ramp_full,
   input  logic       hiccup_done,
   output seq_state_t cur
);
   seq_state_t nxt;

   always_comb begin
      nxt = cur;
      if (!run_req) begin
         nxt = SEQ_OFF;
      end else begin
         case (cur)
            SEQ_OFF:    nxt = SEQ_RAMP;
            SEQ_RAMP:   if (fault) nxt = SEQ_HICCUP;
                        else if (ramp_full) nxt = SEQ_RUN;
            SEQ_RUN:    if (fault) nxt = SEQ_HICCUP;
            SEQ_HICCUP: if (hiccup_done) nxt = SEQ_RAMP;
            default:    nxt = SEQ_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= SEQ_OFF;
      else        cur <= nxt;
   end
endmodule

// File: rtl/fault_hiccup_seq.sv
module fault_hiccup_seq
   import hiccup_pkg::*;
#(
   parameter int SS_W          = 4,
   parameter int SS_DIV        = 2,
   parameter int HICCUP_CYCLES = 40,
   parameter int BLANK_CYCLES  = 50,
   parameter int SYNC_STAGES   = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_req,
   input  logic            oc_flag,
   input  logic            uv_flag,
   input  logic            sc_en,
   output logic            pwm_inhibit,
   output logic            ss_active,
   output logic [SS_W-1:0] ss_level,
   output logic [1:0]      state
);
   generate
      if (SS_W < 1 || SS_W > 16) begin : g_bad_ssw
         $error("SS_W must lie in 1..16");
      end
      if (SS_DIV < 1) begin : g_bad_div
         $error("SS_DIV must be at least 1");
      end
      if (HICCUP_CYCLES < 1) begin : g_bad_hic
         $error("HICCUP_CYCLES must be at least 1");
      end
      if (BLANK_CYCLES < 1) begin : g_bad_blank
         $error("BLANK_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic oc_s, uv_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign oc_s = oc_flag;
         assign uv_s = uv_flag;
      end else begin : g_sync
         logic [1:0] synced;
         hiccup_flag_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
            .clk (clk),
            .rst_n (rst_n),
            .d   ({oc_flag, uv_flag}),
            .q   (synced)
         );
         assign oc_s = synced[1];
         assign uv_s = synced[0];
      end
   endgenerate

   seq_state_t cur;
   logic       in_ramp, in_live, in_hiccup;
   logic       blank_done, hiccup_done, ramp_full;
   logic       fault;
   logic [SS_W-1:0] level_raw;

   assign in_ramp   = (cur == SEQ_RAMP);
   assign in_live   = (cur == SEQ_RAMP) || (cur == SEQ_RUN);
   assign in_hiccup = (cur == SEQ_HICCUP);

   assign fault = oc_s || (sc_en && uv_s && blank_done);

   hiccup_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_req     (run_req),
      .fault       (fault),
      .ramp_full   (ramp_full),
      .hiccup_done (hiccup_done),
      .cur         (cur)
   );

   hiccup_event_timer #(.LIMIT(BLANK_CYCLES)) u_blank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!run_req || !in_live),
      .enable (in_live),
      .done   (blank_done)
   );

   hiccup_event_timer #(.LIMIT(HICCUP_CYCLES - 1)) u_hiccup (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!run_req || !in_hiccup),
      .enable (in_hiccup),
      .done   (hiccup_done)
   );

   hiccup_softstart_ramp #(.SS_W(SS_W), .SS_DIV(SS_DIV)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!run_req || !in_live),
      .enable (in_ramp),
      .level  (level_raw),
      .full   (ramp_full)
   );

   assign pwm_inhibit = !in_live;
   assign ss_active   = in_ramp;
   assign ss_level    = in_live ? level_raw : '0;
   assign state       = cur;
endmodule

// File: rtl/hiccup_seq_checker.sv
module hiccup_seq_checker #(
   parameter int SS_W          = 4,
   parameter int HICCUP_CYCLES = 40,
   parameter int SYNC_STAGES   = 0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run_req,
   input logic            oc_flag,
   input logic            uv_flag,
   input logic            sc_en,
   input logic            pwm_inhibit,
   input logic            ss_active,
   input logic [SS_W-1:0] ss_level,
   input logic [1:0]      state
);
   localparam int HW = $clog2(HICCUP_CYCLES + 2);
   localparam logic [SS_W-1:0] FULL = '1;

   logic [HW-1:0] hic_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hic_run <= '0;
      else if (state == 2'd3)  hic_run <= hic_run + 1'b1;
      else                     hic_run <= '0;
   end

   assert_run_low_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_req |=> state == 2'd0);

   assert_run_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state == 2'd2 |-> (ss_level == FULL && !pwm_inhibit));

   assert_ramp_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state == 2'd1 |=> (state != 2'd1 || ss_level >= $past(ss_level)));

   assert_off_no_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state == 2'd0 |=> state != 2'd2 && state != 2'd3);

   assert_hiccup_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state == 2'd3 |-> (pwm_inhibit && !ss_active && ss_level == '0));

   assert_hiccup_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state == 2'd3 |-> hic_run < HW'(HICCUP_CYCLES));

   generate
      if (SYNC_STAGES == 0) begin : g_cause
         assert_hiccup_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (state != 2'd3 && run_req && !oc_flag && !(sc_en && uv_flag)) |=> state != 2'd3);
      end
   endgenerate
endmodule

bind fault_hiccup_seq hiccup_seq_checker #(
   .SS_W(SS_W), .HICCUP_CYCLES(HICCUP_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .run_req(run_req), .oc_flag(oc_flag),
   .uv_flag(uv_flag), .sc_en(sc_en), .pwm_inhibit(pwm_inhibit),
   .ss_active(ss_active), .ss_level(ss_level), .state(state)
);

// File: tb/fault_hiccup_seq_test.sv
module fault_hiccup_seq_test;
   localparam int SS_W = 4, SS_DIV = 2, HIC = 40, BLANK = 50;
   localparam int FULL = (1 << SS_W) - 1;
   localparam int SS_LEN = FULL * SS_DIV + 1;

   logic clk = 0, rst_n = 0;
   logic run_req = 0, oc_flag = 0, uv_flag = 0, sc_en = 0;
   logic pwm_inhibit, ss_active;
   logic [SS_W-1:0] ss_level;
   logic [1:0] state;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   fault_hiccup_seq #(.SS_W(SS_W), .SS_DIV(SS_DIV), .HICCUP_CYCLES(HIC),
                      .BLANK_CYCLES(BLANK)) uut (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .oc_flag(oc_flag),
      .uv_flag(uv_flag), .sc_en(sc_en), .pwm_inhibit(pwm_inhibit),
      .ss_active(ss_active), .ss_level(ss_level), .state(state));

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic go_off();
      run_req = 0; oc_flag = 0; uv_flag = 0; sc_en = 0;
      tick(); tick();
   endtask

   // count consecutive samples whose state equals s
   task automatic count_in(input logic [1:0] s, output int n);
      n = 0;
      while (state == s && n < 5000) begin n++; tick(); end
   endtask

   task automatic t_reset();
      chk("R1 state", state, 0);
      chk("R1 inhibit", pwm_inhibit, 1);
      chk("R1 ss_active", ss_active, 0);
      chk("R1 level", ss_level, 0);
   endtask

   task automatic t_startup();
      int n = 0, prev = 0, steps_ok = 1;
      run_req = 1; tick();
      chk("R2 enter softstart", state, 1);
      chk("R10 ss_active", ss_active, 1);
      chk("R10 inhibit softstart", pwm_inhibit, 0);
      chk("R2 level start", ss_level, 0);
      while (state == 1 && n < 5000) begin
         if (ss_level != n / SS_DIV) steps_ok = 0;
         prev = ss_level; n++; tick();
      end
      chk("R2 ramp step", steps_ok, 1);
      chk("R3 softstart length", n, SS_LEN);
      chk("R3 run state", state, 2);
      chk("R3 run level", ss_level, FULL);
      chk("R3 run inhibit", pwm_inhibit, 0);
      chk("R10 ss_active in run", ss_active, 0);
   endtask

   task automatic t_oc_run();
      int n;
      oc_flag = 1; tick(); oc_flag = 0;
      chk("R4 oc in run", state, 3);
      chk("R5 hiccup inhibit", pwm_inhibit, 1);
      chk("R5 hiccup level", ss_level, 0);
      count_in(2'd3, n);
      chk("R5 hiccup length", n, HIC);
      chk("R5 restart softstart", state, 1);
      chk("R5 restart level", ss_level, 0);
   endtask

   task automatic t_oc_ramp_held();
      int n;
      go_off();
      oc_flag = 1; tick();
      chk("R4 oc ignored in off", state, 0);
      oc_flag = 0; run_req = 1; tick(); tick(); tick();
      chk("R4 pre softstart", state, 1);
      oc_flag = 1; tick();
      chk("R4 oc in softstart", state, 3);
      count_in(2'd3, n);
      chk("R5 hiccup length with oc held", n, HIC);
      chk("R5 held oc reenters softstart", state, 1);
      tick();
      chk("R4 held oc trips again", state, 3);
   endtask

   task automatic t_short();
      int n;
      go_off();
      sc_en = 1; uv_flag = 1; run_req = 1; tick();
      count_in(2'd1, n);
      begin
         int m; count_in(2'd2, m); n += m;
      end
      chk("R6 R7 blank then trip", n, BLANK + 1);
      chk("R7 short hiccup", state, 3);
      count_in(2'd3, n);
      begin
         int a, b; count_in(2'd1, a); count_in(2'd2, b);
         chk("R6 blanking restarts after hiccup", a + b, BLANK + 1);
      end
   endtask

   task automatic t_sc_disabled();
      go_off();
      sc_en = 0; uv_flag = 1; run_req = 1;
      repeat (200) tick();
      chk("R8 uv ignored when disabled", state, 2);
      chk("R8 inhibit", pwm_inhibit, 0);
   endtask

   task automatic t_drop();
      int n, a, b;
      go_off();
      oc_flag = 1; run_req = 1; tick(); tick(); oc_flag = 0;
      repeat (10) tick();
      chk("R9 in hiccup before drop", state, 3);
      run_req = 0; tick();
      chk("R9 drop from hiccup", state, 0);
      run_req = 1; tick();
      count_in(2'd1, n);
      chk("R9 full softstart after drop", n, SS_LEN);
      run_req = 0; tick();
      chk("R9 drop from run", state, 0);
      run_req = 1; repeat (5) tick();
      run_req = 0; tick();
      chk("R9 drop from softstart", state, 0);
      // blanking window restarts: run long, drop, then short fault
      run_req = 1; repeat (80) tick();
      run_req = 0; tick();
      sc_en = 1; uv_flag = 1; run_req = 1; tick();
      count_in(2'd1, a); count_in(2'd2, b);
      chk("R9 blanking cleared by drop", a + b, BLANK + 1);
   endtask

   initial begin
      repeat (3) tick();
      t_reset();
      rst_n = 1; tick();
      t_reset();
      t_startup();
      t_oc_run();
      t_oc_ramp_held();
      t_short();
      t_sc_disabled();
      t_drop();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule